// File: doc/BRIEF.md
# Codec-Side Serial Link Frame Transmitter

This block is the codec half of a 48 kHz, 256-bit serial audio link. It builds the stream that travels from the codec back to the digital controller. Each rising edge of the frame sync input opens a new frame. The frame starts with a 16-bit tag slot, followed by twelve 20-bit slots, and every bit is sent most significant bit first on a rising edge of the bit clock. The tag slot carries a ready flag for the whole codec and one valid flag for each of the first four data slots.

The surrounding logic supplies a codec-ready level, a pending read response and two 18-bit record samples, each sample with its own valid flag. The read response is the register index being echoed and the 16-bit value read. The block takes a snapshot of all of these at the start of the frame, so they are free to change during the 256 bit times that follow. It applies the rules for gating these fields and places each field at its fixed position in its slot. Every reserved bit is driven as zero, and so is every slot from 5 to 12. The register bank, the converters and power sequencing are outside this block. The block expects the read answer to come from the register logic one frame after the request.

Top module: `ac_link_frame_tx`

## Requirements
- R1: While reset is high, and on the first clock after it, the serial output is 0. No frame begins until a rising edge of frame sync is seen.
- R2: The clock edge that first samples frame sync high, after it was low, drives tag bit 15. Each later edge drives the next bit, for 256 bits in total: 16 tag bits, then slots 1 to 12 of 20 bits each, always from the most significant bit down. Holding frame sync high for more than one cycle starts only one frame.
- R3: In the tag slot, bit 15 is codec ready, bit 14 flags slot 1, bit 13 flags slot 2, bit 12 flags slot 3 and bit 11 flags slot 4. Bits 10 to 0 are 0.
- R4: When a read response is sent, slot 1 carries the 7-bit index in bits 18:12, and bit 19 and bits 11:0 are 0.
- R5: When a read response is sent, slot 2 carries the 16-bit register value in bits 19:4, and bits 3:0 are 0.
- R6: A valid left record sample goes into slot 3, and a valid right sample into slot 4. In both cases the 18 bits sit at bits 19:2, and bits 1:0 are 0.
- R7: Slots 5 to 12 are all zero. After the 256th bit the output stays 0 until the next frame begins.
- R8: When no read response is pending, tag bits 14 and 13 are 0 and slots 1 and 2 are all zero.
- R9: When codec ready is low, tag bits 15 to 11 are all 0 and slots 1 to 4 are all zero, whatever the other inputs are.
- R10: The contents of a frame are taken from the inputs on the start edge of R2. Changing the inputs after that edge does not alter the frame being sent.
- R11: A record sample whose valid flag is low clears its tag bit and sends an all-zero slot. The other channel is not affected.
- R12: A new frame sync rising edge in the middle of a frame abandons the old frame. The same edge drives tag bit 15 of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all outputs are launched on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame marker, synchronous to clk; a rising edge starts a frame |
| codec_ready | input | 1 | Codec operational level sent as tag bit 15 |
| rsp_valid | input | 1 | A read response is pending for this frame |
| rsp_index | input | IDX_W | Register index echoed in slot 1 |
| rsp_data | input | RD_W | Register value returned in slot 2 |
| rec_left | input | SAMPLE_W | Left record sample |
| rec_left_valid | input | 1 | Left sample is valid |
| rec_right | input | SAMPLE_W | Right record sample |
| rec_right_valid | input | 1 | Right sample is valid |
| link_dout | output | 1 | Serial frame data, MSB first |

## Verification
The bench builds the block with its default widths: a 7-bit index, 16-bit read data, 18-bit samples and 20-bit slots. These are the only settings that produce the real 256-bit frame. The bench can therefore compare every bit position against a model built from the slot layout alone, including each slot boundary and the end of the frame. It also covers the corner cases: an early restart, a sync held high for several cycles, a codec that is not ready, and inputs that change after the frame has started.

// File: rtl/ac_tx_pkg.sv
package ac_tx_pkg;

    // Fixed link layout: one tag slot followed by twelve data slots
    localparam int TAG_W       = 16;
    localparam int LINK_SLOT_W = 20;
    localparam int LINK_SLOTS  = 13;

    typedef struct packed {
        logic              ready;
        logic              addr_ok;
        logic              data_ok;
        logic              left_ok;
        logic              right_ok;
        logic [TAG_W-6:0]  pad;
    } tag_t;

    typedef enum logic [2:0] {
        SK_TAG   = 3'd0,
        SK_ADDR  = 3'd1,
        SK_DATA  = 3'd2,
        SK_LEFT  = 3'd3,
        SK_RIGHT = 3'd4,
        SK_RSVD  = 3'd5
    } slot_kind_e;

    function automatic slot_kind_e slot_kind(input int unsigned idx);
        case (idx)
            0:       return SK_TAG;
            1:       return SK_ADDR;
            2:       return SK_DATA;
            3:       return SK_LEFT;
            4:       return SK_RIGHT;
            default: return SK_RSVD;
        endcase
    endfunction

    function automatic tag_t make_tag(input logic rdy, input logic rsp,
                                      input logic lv, input logic rv);
        tag_t t;
        t.ready    = rdy;
        t.addr_ok  = rsp;
        t.data_ok  = rsp;
        t.left_ok  = lv;
        t.right_ok = rv;
        t.pad      = '0;
        return t;
    endfunction

endpackage

// File: rtl/ac_tx_edge.sv
module ac_tx_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    assign rise = level_in & ~prev_q & ~rst;
endmodule

// File: rtl/ac_tx_snapshot.sv
module ac_tx_snapshot
    import ac_tx_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int RD_W     = 16,
    parameter int SAMPLE_W = 18,
    parameter int CHANS    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           capture,
    input  logic                           codec_ready,
    input  logic                           rsp_valid,
    input  logic [IDX_W-1:0]               rsp_index,
    input  logic [RD_W-1:0]                rsp_data,
    input  logic [CHANS-1:0][SAMPLE_W-1:0] rec_in,
    input  logic [CHANS-1:0]               rec_valid,
    output tag_t                           sel_tag,
    output logic [IDX_W-1:0]               sel_index,
    output logic [RD_W-1:0]                sel_data,
    output logic [CHANS-1:0][SAMPLE_W-1:0] sel_rec
);
    // Gated view of the live inputs
    logic                           rsp_ok;
    logic [CHANS-1:0]               rec_ok;
    logic [IDX_W-1:0]               live_index;
    logic [RD_W-1:0]                live_data;
    logic [CHANS-1:0][SAMPLE_W-1:0] live_rec;
    tag_t                           live_tag;

    // Captured copy used for the rest of the frame
    tag_t                           snap_tag;
    logic [IDX_W-1:0]               snap_index;
    logic [RD_W-1:0]                snap_data;
    logic [CHANS-1:0][SAMPLE_W-1:0] snap_rec;

    assign rsp_ok     = codec_ready & rsp_valid;
    assign live_index = rsp_ok ? rsp_index : '0;
    assign live_data  = rsp_ok ? rsp_data  : '0;

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        assign rec_ok[ch]   = codec_ready & rec_valid[ch];
        assign live_rec[ch] = rec_ok[ch] ? rec_in[ch] : '0;

        always_ff @(posedge clk) begin
            if (rst)          snap_rec[ch] <= '0;
            else if (capture) snap_rec[ch] <= live_rec[ch];
        end

        assign sel_rec[ch] = capture ? live_rec[ch] : snap_rec[ch];
    end

    assign live_tag = make_tag(codec_ready, rsp_ok, rec_ok[0], rec_ok[CHANS-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_tag   <= '0;
            snap_index <= '0;
            snap_data  <= '0;
        end else if (capture) begin
            snap_tag   <= live_tag;
            snap_index <= live_index;
            snap_data  <= live_data;
        end
    end

    assign sel_tag   = capture ? live_tag   : snap_tag;
    assign sel_index = capture ? live_index : snap_index;
    assign sel_data  = capture ? live_data  : snap_data;
endmodule

// File: rtl/ac_tx_seq.sv
module ac_tx_seq
    import ac_tx_pkg::*;
#(
    parameter int SLOT_W = LINK_SLOT_W,
    parameter int SLOTS  = LINK_SLOTS,
    localparam int SLOT_CW = $clog2(SLOTS),
    localparam int BIT_CW  = $clog2(SLOT_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               send,
    output logic               run,
    output logic [SLOT_CW-1:0] cur_slot,
    output logic [BIT_CW-1:0]  cur_bit
);
    localparam logic [SLOT_CW-1:0] LAST_SLOT = SLOT_CW'(SLOTS - 1);
    localparam logic [BIT_CW-1:0]  TAG_TOP   = BIT_CW'(TAG_W - 1);
    localparam logic [BIT_CW-1:0]  SLOT_TOP  = BIT_CW'(SLOT_W - 1);

    logic               active_q;
    logic [SLOT_CW-1:0] slot_q;
    logic [BIT_CW-1:0]  bit_q;
    logic               at_end;

    assign send     = start | active_q;
    assign run      = active_q;
    assign cur_slot = start ? '0      : slot_q;
    assign cur_bit  = start ? TAG_TOP : bit_q;
    assign at_end   = (cur_bit == '0) && (cur_slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            bit_q    <= '0;
        end else if (send) begin
            active_q <= ~at_end;
            if (cur_bit == '0) begin
                slot_q <= at_end ? '0 : cur_slot + 1'b1;
                bit_q  <= SLOT_TOP;
            end else begin
                slot_q <= cur_slot;
                bit_q  <= cur_bit - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ac_tx_bitsel.sv
module ac_tx_bitsel
    import ac_tx_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int RD_W     = 16,
    parameter int SAMPLE_W = 18,
    parameter int SLOT_W   = LINK_SLOT_W,
    parameter int SLOTS    = LINK_SLOTS,
    localparam int SLOT_CW = $clog2(SLOTS),
    localparam int BIT_CW  = $clog2(SLOT_W)
) (
    input  tag_t                       tag,
    input  logic [IDX_W-1:0]           index,
    input  logic [RD_W-1:0]            data,
    input  logic [1:0][SAMPLE_W-1:0]   rec,
    input  logic [SLOT_CW-1:0]         cur_slot,
    input  logic [BIT_CW-1:0]          cur_bit,
    output logic                       bit_out
);
    // Field offsets inside a data slot (MSB-justified)
    localparam int ADDR_LSB = SLOT_W - 1 - IDX_W;
    localparam int DATA_LSB = SLOT_W - RD_W;
    localparam int REC_LSB  = SLOT_W - SAMPLE_W;

    logic [SLOT_W-1:0] word;

    always_comb begin
        word = '0;
        case (slot_kind(int'(cur_slot)))
            SK_TAG:   word = SLOT_W'(tag);
            SK_ADDR:  word = SLOT_W'(index) << ADDR_LSB;
            SK_DATA:  word = SLOT_W'(data)  << DATA_LSB;
            SK_LEFT:  word = SLOT_W'(rec[0]) << REC_LSB;
            SK_RIGHT: word = SLOT_W'(rec[1]) << REC_LSB;
            default:  word = '0;
        endcase
        bit_out = word[cur_bit];
    end
endmodule

// File: rtl/ac_link_frame_tx.sv
module ac_link_frame_tx
    import ac_tx_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int RD_W     = 16,
    parameter int SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_sync,
    input  logic                codec_ready,
    input  logic                rsp_valid,
    input  logic [IDX_W-1:0]    rsp_index,
    input  logic [RD_W-1:0]     rsp_data,
    input  logic [SAMPLE_W-1:0] rec_left,
    input  logic                rec_left_valid,
    input  logic [SAMPLE_W-1:0] rec_right,
    input  logic                rec_right_valid,
    output logic                link_dout
);
    localparam int SLOT_CW = $clog2(LINK_SLOTS);
    localparam int BIT_CW  = $clog2(LINK_SLOT_W);

    logic                      start;
    logic                      send;
    logic                      run;
    logic [SLOT_CW-1:0]        cur_slot;
    logic [BIT_CW-1:0]         cur_bit;
    tag_t                      sel_tag;
    logic [IDX_W-1:0]          sel_index;
    logic [RD_W-1:0]           sel_data;
    logic [1:0][SAMPLE_W-1:0]  sel_rec;
    logic                      next_bit;
    logic                      dout_q;

    ac_tx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (frame_sync),
        .rise     (start)
    );

    ac_tx_snapshot #(
        .IDX_W    (IDX_W),
        .RD_W     (RD_W),
        .SAMPLE_W (SAMPLE_W),
        .CHANS    (2)
    ) u_snap (
        .clk         (clk),
        .rst         (rst),
        .capture     (start),
        .codec_ready (codec_ready),
        .rsp_valid   (rsp_valid),
        .rsp_index   (rsp_index),
        .rsp_data    (rsp_data),
        .rec_in      ({rec_right, rec_left}),
        .rec_valid   ({rec_right_valid, rec_left_valid}),
        .sel_tag     (sel_tag),
        .sel_index   (sel_index),
        .sel_data    (sel_data),
        .sel_rec     (sel_rec)
    );

    ac_tx_seq #(
        .SLOT_W (LINK_SLOT_W),
        .SLOTS  (LINK_SLOTS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .send     (send),
        .run      (run),
        .cur_slot (cur_slot),
        .cur_bit  (cur_bit)
    );

    ac_tx_bitsel #(
        .IDX_W    (IDX_W),
        .RD_W     (RD_W),
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (LINK_SLOT_W),
        .SLOTS    (LINK_SLOTS)
    ) u_sel (
        .tag      (sel_tag),
        .index    (sel_index),
        .data     (sel_data),
        .rec      (sel_rec),
        .cur_slot (cur_slot),
        .cur_bit  (cur_bit),
        .bit_out  (next_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_q <= 1'b0;
        else     dout_q <= send & next_bit;
    end

    assign link_dout = dout_q;
endmodule

// File: rtl/ac_link_frame_tx_chk.sv
module ac_link_frame_tx_chk
    import ac_tx_pkg::*;
#(
    parameter int SLOT_CW = 4,
    parameter int BIT_CW  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               codec_ready,
    input logic               link_dout,
    input logic               start,
    input logic               send,
    input logic               run,
    input logic [SLOT_CW-1:0] cur_slot,
    input logic [BIT_CW-1:0]  cur_bit
);
    AST_RESET_LOW: assert property (@(posedge clk) $past(rst) |-> !link_dout); // R1

    AST_FRAME_ENTRY: assert property (@(posedge clk) disable iff (rst)
        start |=> (run && cur_slot == '0 && cur_bit == BIT_CW'(TAG_W - 2))); // R2

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cur_slot < SLOT_CW'(LINK_SLOTS) && cur_bit < BIT_CW'(LINK_SLOT_W))); // R2

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cur_bit == '0 && cur_slot != SLOT_CW'(LINK_SLOTS - 1))
        |=> (start || cur_bit == BIT_CW'(LINK_SLOT_W - 1))); // R2

    AST_TAG_READY: assert property (@(posedge clk) disable iff (rst)
        start |=> (link_dout == $past(codec_ready))); // R3

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !send |=> !link_dout); // R7
endmodule

bind ac_link_frame_tx ac_link_frame_tx_chk #(
    .SLOT_CW ($clog2(ac_tx_pkg::LINK_SLOTS)),
    .BIT_CW  ($clog2(ac_tx_pkg::LINK_SLOT_W))
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .codec_ready (codec_ready),
    .link_dout   (link_dout),
    .start       (start),
    .send        (send),
    .run         (run),
    .cur_slot    (cur_slot),
    .cur_bit     (cur_bit)
);

// File: tb/sim_ac_link_frame_tx.sv
module sim_ac_link_frame_tx;

    typedef struct {
        bit    exp;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [6:0]  rsp_index = '0;
    logic [15:0] rsp_data = '0;
    logic [17:0] rec_left = '0;
    logic        rec_left_valid = 1'b0;
    logic [17:0] rec_right = '0;
    logic        rec_right_valid = 1'b0;
    logic        link_dout;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #4 clk = ~clk;

    ac_link_frame_tx u0 (
        .clk             (clk),
        .rst             (rst),
        .frame_sync      (frame_sync),
        .codec_ready     (codec_ready),
        .rsp_valid       (rsp_valid),
        .rsp_index       (rsp_index),
        .rsp_data        (rsp_data),
        .rec_left        (rec_left),
        .rec_left_valid  (rec_left_valid),
        .rec_right       (rec_right),
        .rec_right_valid (rec_right_valid),
        .link_dout       (link_dout)
    );

    // Monitor: one expected bit per clock, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (link_dout !== it.exp) begin
                fails++;
                $display("FAIL %s: got %0b expected %0b at %0t", it.req, link_dout, it.exp, $time);
            end
        end
    end

    task automatic push_bits(input logic [19:0] w, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) q.push_back('{w[i], req});
    endtask

    // Driver: raise sync and queue the frame expected from the requirements
    task automatic start_frame(input bit rdy, input bit rv, input logic [6:0] idx,
                               input logic [15:0] dat, input bit lv, input logic [17:0] l,
                               input bit rr, input logic [17:0] r, input int hold,
                               input string note);
        bit ok1, ok3, ok4;
        logic [19:0] tagw, s1, s2, s3, s4;
        @(posedge clk); #1;
        codec_ready = rdy; rsp_valid = rv; rsp_index = idx; rsp_data = dat;
        rec_left_valid = lv; rec_left = l; rec_right_valid = rr; rec_right = r;
        frame_sync = 1'b1;
        if (q.size() == 0) q.push_back('{1'b0, "R7 idle before frame"});
        else while (q.size() > 1) void'(q.pop_back());
        ok1 = rdy && rv;   // R8 and R9 gating
        ok3 = rdy && lv;   // R11 and R9 gating
        ok4 = rdy && rr;
        tagw = {4'b0, rdy, ok1, ok1, ok3, ok4, 11'b0};
        s1 = ok1 ? {1'b0, idx, 12'b0} : 20'b0;
        s2 = ok1 ? {dat, 4'b0} : 20'b0;
        s3 = ok3 ? {l, 2'b0} : 20'b0;
        s4 = ok4 ? {r, 2'b0} : 20'b0;
        push_bits(tagw, 16, {"R3 tag ", note});
        push_bits(s1, 20, {"R4 slot1 ", note});
        push_bits(s2, 20, {"R5 slot2 ", note});
        push_bits(s3, 20, {"R6 slot3 ", note});
        push_bits(s4, 20, {"R6 slot4 ", note});
        for (int s = 5; s <= 12; s++) push_bits(20'b0, 20, {"R7 reserved ", note});
        for (int i = 0; i < 3; i++) q.push_back('{1'b0, "R7 after frame end"});
        repeat (hold) @(posedge clk);
        #1 frame_sync = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (link_dout !== 1'b0) begin
            fails++;
            $display("FAIL R1: got %0b expected 0 during reset", link_dout);
        end
        @(posedge clk); #1 rst = 1'b0;
        for (int i = 0; i < 6; i++) q.push_back('{1'b0, "R1 idle after reset"});
        drain();

        // R3 R4 R5 R6: everything valid
        start_frame(1, 1, 7'h2A, 16'hBEEF, 1, 18'h2_5A5C, 1, 18'h1_3C3F, 1, "all valid");
        drain();
        // R2: sync held high several cycles starts one frame
        start_frame(1, 1, 7'h7F, 16'hFFFF, 1, 18'h3_FFFF, 1, 18'h3_FFFF, 6, "R2 long sync");
        drain();
        // R8: no read response pending
        start_frame(1, 0, 7'h55, 16'h1234, 1, 18'h0_0001, 1, 18'h2_0000, 1, "R8 no response");
        drain();
        // R9: codec not ready
        start_frame(0, 1, 7'h11, 16'hA5A5, 1, 18'h3_0F0F, 1, 18'h1_F0F0, 2, "R9 not ready");
        drain();
        // R11: only left valid, then only right valid
        start_frame(1, 1, 7'h01, 16'h0001, 1, 18'h2_AAAA, 0, 18'h1_5555, 1, "R11 left only");
        drain();
        start_frame(1, 0, 7'h40, 16'h8000, 0, 18'h2_AAAA, 1, 18'h1_5555, 1, "R11 right only");
        drain();
        // R10: inputs change while the frame shifts out
        start_frame(1, 1, 7'h33, 16'h0F0F, 1, 18'h1_2345, 1, 18'h2_6789, 1, "R10 snapshot");
        repeat (40) begin
            @(posedge clk); #1;
            rsp_index = rsp_index + 7'd3; rsp_data = ~rsp_data;
            rec_left = rec_left ^ 18'h3_FFFF; rec_right = rec_right + 18'd77;
            codec_ready = ~codec_ready; rsp_valid = ~rsp_valid;
        end
        drain();
        // R12: restart in the middle of a frame
        start_frame(1, 1, 7'h0C, 16'hC0DE, 1, 18'h0_ABCD, 1, 18'h3_1111, 1, "R12 abandoned");
        while (q.size() > 150) @(posedge clk);
        start_frame(1, 1, 7'h61, 16'h7E57, 0, 18'h0, 1, 18'h2_2222, 1, "R12 restarted");
        drain();
        // Back-to-back frames with varied data
        for (int k = 0; k < 6; k++) begin
            start_frame(k != 3, k[0], 7'(k * 19 + 5), 16'(k * 16'h1357 + 16'h0101), k != 2,
                        18'(k * 18'h0_9A3B + 18'h7), k != 4, 18'(k * 18'h1_2B4D + 18'h3),
                        1 + k % 3, "sweep");
            drain();
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: got hung run expected completion");
            finish_run();
        end
    end
endmodule